// File: doc/BRIEF.md
# Two-Wire Oscillator Trim Register Slave

This block is a slave on a two-wire serial bus (one clock line, one data line). A fast system clock samples both lines, and the block keeps a small register space behind a fixed 7-bit device address. One register holds an 8-bit trim code. That code drives a parallel output into a digitally adjusted crystal oscillator, where it sets the load capacitance. A higher code adds capacitance and so lowers the oscillator frequency.

A bus master writes by sending the device address with the write flag, then a register address, then one or more data bytes. The register pointer advances by one after each data byte. To read, the master first sets the pointer with a short write. It then sends a repeated start and the device address with the read flag, and the slave shifts out the addressed byte. The slave pulls the data line low through an open-drain enable, both for its acknowledges and for the zero bits of read data. Each write to the trim register raises a one-cycle strobe.

Top module: `trim_link_slave`

## Requirements
- R1: During and right after synchronous reset, `trim_code` is 80h, `sda_oe` is 0 and `trim_update` is 0.
- R2: A falling data line while the clock line is high marks a start. A rising data line while the clock line is high marks a stop. A start received in the middle of any byte abandons the frame in progress, and the next byte is read as a device address.
- R3: When the first byte after a start carries the device address 1101001 in bits 7:1, the slave acknowledges it by holding the data line low for the whole 9th clock. Any other address gets no acknowledge, and the slave ignores the bus until the next start, so no register changes.
- R4: Every byte moves most significant bit first, both into the slave and out of it.
- R5: A write frame consists of the address byte with bit 0 = 0, then a register address byte, then data. The slave acknowledges each of these bytes, and a data byte sent to register 13h appears on `trim_code`.
- R6: Each further data byte in the same write frame goes to the register address one higher than the byte before it.
- R7: After the pointer is set, a repeated start and the address byte with bit 0 = 1 make the slave send the byte at the pointer. An acknowledge from the master (data low on the 9th clock) continues the read. A not-acknowledge ends it.
- R8: A write to any address other than 13h is acknowledged but discarded. A read from any such address returns 00h.
- R9: `trim_update` is high for exactly one system cycle for each byte written to 13h. `trim_code` changes only in a cycle where `trim_update` is high.
- R10: `sda_oe` changes only while the synchronised clock line is low, so the slave never creates a false start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 MHz |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| trim_code | output | 8 | Oscillator trim code (register 13h) |
| trim_update | output | 1 | One-cycle strobe on each write to register 13h |

## Verification
The bench sends the code 01h and reads it back. A design that shifted least significant bit first would show 80h there instead. It begins an auto-increment write at 12h, so a design with no pointer advance would put the wrong byte into the trim register. It also sends a near-miss device address: a slave that ignored bit 0 of the address would acknowledge it and overwrite the trim code. A start injected halfway through a data byte must leave only the later frame's value. An engine that did not restart on a start would instead commit a mixed byte or drop the new frame.

// File: rtl/tls_pkg.sv
package tls_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_REG, S_REG_ACK,
        S_WR, S_WR_ACK, S_RD, S_RD_ACK, S_SKIP
    } frame_st_t;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start_c;
        logic stop_c;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [BYTE_W-1:0] b,
                                     input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/tls_line_sync.sv
module tls_line_sync
    import tls_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw, lvl, prv;
    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-1:0], raw[g]};
        end
        assign lvl[g] = chain[STAGES-1];
        assign prv[g] = chain[STAGES];
    end

    always_comb begin
        ev.scl_lvl  = lvl[1];
        ev.sda_lvl  = lvl[0];
        ev.scl_rise = lvl[1] & ~prv[1];
        ev.scl_fall = ~lvl[1] & prv[1];
        ev.start_c  = lvl[1] & prv[1] & prv[0] & ~lvl[0];
        ev.stop_c   = lvl[1] & prv[1] & ~prv[0] & lvl[0];
    end
endmodule

// File: rtl/tls_frame_fsm.sv
module tls_frame_fsm
    import tls_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe,
    output frame_st_t         state_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    frame_st_t         st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, ptr, nb;
    logic              ack_on, is_rd;

    assign nb      = {shreg[BYTE_W-2:0], sda_lvl};
    assign rd_addr = ptr;
    assign state_o = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;  cnt <= '0;  shreg <= '0;  ptr <= '0;
            sda_oe <= 1'b0;  ack_on <= 1'b0;  is_rd <= 1'b0;
            wr_en <= 1'b0;  wr_addr <= '0;  wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_c) begin
                st <= S_ADDR;  cnt <= '0;  sda_oe <= 1'b0;  ack_on <= 1'b0;
            end else if (stop_c) begin
                st <= S_IDLE;  sda_oe <= 1'b0;  ack_on <= 1'b0;
            end else begin
                case (st)
                    S_ADDR, S_REG, S_WR: if (scl_rise) begin
                        shreg <= nb;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            if (st == S_ADDR) begin
                                if (dev_hit(nb, DEV_ADDR)) begin
                                    is_rd <= nb[0];
                                    st    <= S_ADDR_ACK;
                                end else begin
                                    st <= S_SKIP;
                                end
                            end else if (st == S_REG) begin
                                ptr <= nb;
                                st  <= S_REG_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= nb;
                                ptr     <= ptr + 1'b1;
                                st      <= S_WR_ACK;
                            end
                        end
                    end
                    S_ADDR_ACK, S_REG_ACK, S_WR_ACK: if (scl_fall) begin
                        if (!ack_on) begin
                            sda_oe <= 1'b1;
                            ack_on <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            cnt    <= '0;
                            if (st == S_ADDR_ACK && is_rd) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                ptr    <= ptr + 1'b1;
                                st     <= S_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= (st == S_ADDR_ACK) ? S_REG : S_WR;
                            end
                        end
                    end
                    S_RD: if (scl_fall) begin
                        if (cnt == LAST) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            st     <= S_RD_ACK;
                        end else begin
                            shreg  <= shreg << 1;
                            sda_oe <= ~shreg[BYTE_W-2];
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    S_RD_ACK: begin
                        if (scl_rise && sda_lvl) begin
                            st <= S_SKIP;
                        end else if (scl_fall) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            ptr    <= ptr + 1'b1;
                            st     <= S_RD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tls_regs.sv
module tls_regs
    import tls_pkg::*;
#(
    parameter logic [BYTE_W-1:0] TRIM_ADDR  = 8'h13,
    parameter logic [BYTE_W-1:0] TRIM_RESET = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] trim_code,
    output logic              trim_update
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trim_code   <= TRIM_RESET;
            trim_update <= 1'b0;
        end else begin
            trim_update <= 1'b0;
            if (wr_en && wr_addr == TRIM_ADDR) begin
                trim_code   <= wr_data;
                trim_update <= 1'b1;
            end
        end
    end

    assign rd_data = (rd_addr == TRIM_ADDR) ? trim_code : '0;
endmodule

// File: rtl/trim_link_slave.sv
module trim_link_slave
    import tls_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'b1101001,
    parameter logic [BYTE_W-1:0] TRIM_ADDR   = 8'h13,
    parameter logic [BYTE_W-1:0] TRIM_RESET  = 8'h80,
    parameter int                SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] trim_code,
    output logic       trim_update
);
    bus_ev_t           ev;
    frame_st_t         st;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

    tls_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    tls_frame_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst(rst),
        .sda_lvl(ev.sda_lvl), .scl_rise(ev.scl_rise), .scl_fall(ev.scl_fall),
        .start_c(ev.start_c), .stop_c(ev.stop_c),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sda_oe(sda_oe), .state_o(st)
    );

    tls_regs #(.TRIM_ADDR(TRIM_ADDR), .TRIM_RESET(TRIM_RESET)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .trim_code(trim_code), .trim_update(trim_update)
    );
endmodule

// File: rtl/tls_checker.sv
module tls_checker
    import tls_pkg::*;
#(
    parameter logic [7:0] TRIM_RESET = 8'h80
) (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic [7:0] trim_code,
    input logic       trim_update,
    input logic       scl_lvl,
    input logic       start_c,
    input logic       stop_c,
    input frame_st_t  st
);
    p_reset_values_r1: assert property (@(posedge clk)
        rst |=> (trim_code == TRIM_RESET && !sda_oe && !trim_update));

    p_update_single_r9: assert property (@(posedge clk) disable iff (rst)
        trim_update |=> !trim_update);

    p_trim_needs_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        (trim_code != $past(trim_code)) |-> trim_update);

    p_oe_still_scl_high_r10: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl) && !$past(start_c) && !$past(stop_c))
        |-> $stable(sda_oe));

    p_skip_released_r3: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE || st == S_SKIP) |-> !sda_oe);
endmodule

bind trim_link_slave tls_checker #(.TRIM_RESET(TRIM_RESET)) u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .trim_code(trim_code),
    .trim_update(trim_update), .scl_lvl(ev.scl_lvl),
    .start_c(ev.start_c), .stop_c(ev.stop_c), .st(st)
);

// File: tb/tb_trim_link_slave.sv
module tb_trim_link_slave;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'b1101001;

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, trim_update;
    logic [7:0] trim_code;
    wire  sda_line = sda_m & ~sda_oe;

    int tests = 0, fails = 0, upd_cnt = 0, oe_hi_changes = 0;
    bit done = 0;
    logic [7:0] model_trim = 8'h80;

    always #4 clk = ~clk;

    trim_link_slave dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .trim_code(trim_code), .trim_update(trim_update)
    );

    logic oe_q = 1'b0;
    always @(posedge clk) begin
        if (!rst && trim_update) upd_cnt++;
        if (!rst && scl_m && sda_oe !== oe_q) oe_hi_changes++;
        oe_q <= sda_oe;
    end

    function automatic logic [7:0] exp_read(input logic [7:0] ra, input logic [7:0] t);
        return (ra == 8'h13) ? t : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
        s = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(~m_ack, s);
    endtask

    // write n (1 or 2) data bytes; returns acks as a bit mask
    task automatic wr_frame(input logic [6:0] dev, input logic [7:0] ra,
                            input logic [7:0] d0, input logic [7:0] d1,
                            input int n, output logic [3:0] acks);
        logic a;
        acks = '0;
        bus_start();
        send_byte({dev, 1'b0}, a); acks[0] = a;
        send_byte(ra, a);          acks[1] = a;
        send_byte(d0, a);          acks[2] = a;
        if (n > 1) begin send_byte(d1, a); acks[3] = a; end
        bus_stop();
    endtask

    task automatic rd_frame(input logic [7:0] ra, output logic [7:0] v,
                            output logic [2:0] acks);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); acks[0] = a;
        send_byte(ra, a);          acks[1] = a;
        bus_start();
        send_byte({DEV, 1'b1}, a); acks[2] = a;
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] wa;
        logic [2:0] ra3;
        logic [7:0] v;
        logic a;
        int u0;
        u0 = 0;
        void'($urandom(32'h5EED));
        tick(5);
        // R1: reset values
        chk("R1 trim", trim_code, 8'h80);
        chk("R1 oe", sda_oe, 0);
        chk("R1 upd", trim_update, 0);
        rst = 1'b0;
        tick(10);

        // R3 R5 R9: plain write to trim
        wr_frame(DEV, 8'h13, 8'h5A, 8'h00, 1, wa);
        chk("R3 R5 acks", wa[2:0], 3'b111);
        chk("R5 trim", trim_code, 8'h5A);
        chk("R9 one strobe", upd_cnt, 1);

        // R4: MSB-first both ways
        wr_frame(DEV, 8'h13, 8'h01, 8'h00, 1, wa);
        chk("R4 write order", trim_code, 8'h01);
        rd_frame(8'h13, v, ra3);
        chk("R4 R7 read acks", ra3, 3'b111);
        chk("R4 R7 read data", v, 8'h01);

        // R6 R8: auto-increment from 12h, 12h discarded
        wr_frame(DEV, 8'h12, 8'h11, 8'hC3, 2, wa);
        chk("R6 R8 acks", wa, 4'b1111);
        chk("R6 trim", trim_code, 8'hC3);
        chk("R9 count", upd_cnt, 3);
        rd_frame(8'h12, v, ra3);
        chk("R8 read unimpl", v, 8'h00);

        // R3: near-miss address ignored
        wr_frame(7'b1101000, 8'h13, 8'hEE, 8'h00, 1, wa);
        chk("R3 no ack", wa[2:0], 3'b000);
        chk("R3 trim kept", trim_code, 8'hC3);
        chk("R3 no strobe", upd_cnt, 3);

        // R2: start in the middle of a data byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h13, a);
        for (int i = 0; i < 4; i++) clock_bit(i[0], a);
        bus_start();
        send_byte({DEV, 1'b0}, a);
        chk("R2 restart ack", a, 1);
        send_byte(8'h13, a);
        send_byte(8'h3C, a);
        bus_stop();
        chk("R2 trim", trim_code, 8'h3C);
        chk("R2 count", upd_cnt, 4);
        model_trim = 8'h3C;

        // R7: read with master nack ends read; bus still usable
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h13, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b0, v);
        chk("R7 nack path data", v, 8'h3C);
        bus_stop();
        rd_frame(8'h13, v, ra3);
        chk("R7 after stop", v, 8'h3C);

        // random mix
        for (int k = 0; k < 20; k++) begin
            logic [31:0] r;
            logic [7:0] rad, dat;
            r   = $urandom;
            rad = r[0] ? 8'h13 : r[15:8];
            dat = r[23:16];
            u0  = upd_cnt;
            wr_frame(DEV, rad, dat, 8'h00, 1, wa);
            chk("R5 R8 rnd acks", wa[2:0], 3'b111);
            if (rad == 8'h13) model_trim = dat;
            chk("R5 R8 rnd trim", trim_code, model_trim);
            chk("R9 rnd strobe", upd_cnt - u0, (rad == 8'h13) ? 1 : 0);
            rd_frame(rad, v, ra3);
            chk("R7 R8 rnd read", v, exp_read(rad, model_trim));
        end

        // R10: no drive change while clock high
        chk("R10 oe stable high", oe_hi_changes, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule